// File: doc/BRIEF.md
# Triggered Circular-Buffer Capture Unit

This block is an on-chip capture unit for debug. While it is armed it stores one sample of a data bus per clock into a ring memory of `2^ADDR_W` entries. It watches a separate trigger bus, whose width is a parameter. It stops once a masked trigger match has been followed by a programmable number of further samples. The trigger is built from a compare word and a mask word. A mask bit of 1 makes the matching trigger bit take part in the compare, and a mask bit of 0 leaves that bit out.

A host reaches everything through a small Wishbone-style slave port that uses word addresses. The low part of the word map is the sample memory, packed into 32-bit words. Four control words follow it directly: status, stop address, trigger compare value and trigger mask. Once capture has finished, the host reads the stop address. It then walks the ring from that entry to get the samples in the order they were taken.

Top module: `la_capture_top`

## Requirements
- R1: While running, each clock writes the current sample at the write pointer and advances the pointer by one, wrapping from the last entry to entry 0.
- R2: Sample word `w` holds samples `w*L .. w*L+L-1` with `L = 32/SAMPLE_W`, the lowest-addressed sample in bits `SAMPLE_W-1:0` and each next one in the next higher lane; words 0 .. `NWORDS-1` (`NWORDS = 2^ADDR_W / L`) are the sample region.
- R3: Word `NWORDS` is status: bit 7 = running, bit 6 = finished, all other bits zero; the two flags are never both set. Word `NWORDS+1` reads the stop address, `NWORDS+2` the compare value, `NWORDS+3` the mask (all zero-extended).
- R4: The trigger fires on the first running cycle where every trigger bit with mask bit 1 equals the compare bit; bits with mask bit 0 are ignored.
- R5: After the trigger sample, exactly P more samples are stored (P = post-trigger count, 0 .. depth-1). Capture then stops, the finished flag sets, and the stop address becomes (trigger address + P + 1) mod depth.
- R6: Writing the status word with data bit 7 = 1 arms: running = 1, finished = 0, write pointer = 0, trigger forgotten. A status write with bit 7 = 0 changes nothing.
- R7: A bus request is acknowledged on the clock after it is seen, for exactly one cycle, with read data valid in that cycle. Writes to the sample region have no effect.
- R8: Reset clears running, finished, write pointer, stop address, compare value and mask (so any sample matches) and sets P to depth/2.
- R9: Writing word `NWORDS+1` sets P from its low `ADDR_W` bits; reading that word still returns the stop address.
- R10: Once the ring is full, reading entries stop, stop+1, … (mod depth) gives the stored samples oldest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_data | input | SAMPLE_W | Bus being recorded |
| trig_in | input | TRIG_W | Bus compared against the trigger |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Bus write enable |
| bus_adr | input | BUS_AW | Word address |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Read data, valid with ack |
| bus_ack | output | 1 | One-cycle acknowledge |

## Verification
The checker enforces the following on every clock:
- the running and finished flags never overlap;
- the pointer advances by one each running cycle and wraps;
- the stop address moves only on the stop event and equals the write pointer when finished rises;
- arming takes effect on the next cycle;
- the acknowledge arrives one cycle after the request and lasts one cycle.

Other behaviour shows only in the bench's scenarios: the trigger choosing the right sample under a partial mask, the exact number of post-trigger samples for every P, lane packing, and the oldest-first order after wrap.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;

  // Masked compare: every bit selected by care must equal value.
  function automatic logic trig_match(input logic [31:0] sig,
                                      input logic [31:0] value,
                                      input logic [31:0] care);
    return ((sig ^ value) & care) == 32'd0;
  endfunction

  // Number of samples held by one 32-bit bus word.
  function automatic int lanes_per_word(input int sample_w);
    return 32 / sample_w;
  endfunction

  // Status word layout.
  localparam int ST_RUN_BIT  = 7;
  localparam int ST_DONE_BIT = 6;
  localparam int ST_ARM_BIT  = 7;

endpackage

// File: rtl/la_sample_ram.sv
module la_sample_ram #(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 9,
  parameter int WORD_AW  = 8
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic [WORD_AW-1:0]  rd_word,
  output logic [31:0]         rd_packed
);
  import la_cap_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = lanes_per_word(SAMPLE_W);

  logic [SAMPLE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Lane l of a word carries sample rd_word*LANES + l.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr;
    assign lane_addr = ADDR_W'(rd_word) * ADDR_W'(LANES) + ADDR_W'(l);
    assign rd_packed[l*SAMPLE_W +: SAMPLE_W] = mem[lane_addr];
  end

endmodule

// File: rtl/la_capture_ctl.sv
module la_capture_ctl #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              hit,
  input  logic [ADDR_W-1:0] post_cnt,
  output logic              run,
  output logic              done,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] stop_cnt,
  output logic              wr_en,
  output logic              trig_fire,
  output logic              cap_stop
);

  logic              trig_seen;
  logic [ADDR_W-1:0] left;

  assign wr_en     = run;
  assign trig_fire = run && !trig_seen && hit;
  assign cap_stop  = run && ((trig_fire && post_cnt == '0) ||
                             (trig_seen && left == ADDR_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      done      <= 1'b0;
      trig_seen <= 1'b0;
      wr_ptr    <= '0;
      stop_cnt  <= '0;
      left      <= '0;
    end else if (arm) begin
      run       <= 1'b1;
      done      <= 1'b0;
      trig_seen <= 1'b0;
      wr_ptr    <= '0;
    end else if (run) begin
      wr_ptr <= wr_ptr + ADDR_W'(1);
      if (trig_fire) begin
        trig_seen <= 1'b1;
        left      <= post_cnt;
      end else if (trig_seen) begin
        left <= left - ADDR_W'(1);
      end
      if (cap_stop) begin
        run      <= 1'b0;
        done     <= 1'b1;
        stop_cnt <= wr_ptr + ADDR_W'(1);
      end
    end
  end

endmodule

// File: rtl/la_bus_regs.sv
module la_bus_regs #(
  parameter int ADDR_W = 9,
  parameter int TRIG_W = 8,
  parameter int BUS_AW = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cyc,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_adr,
  input  logic [31:0]       bus_wdat,
  output logic [31:0]       bus_rdat,
  output logic              bus_ack,
  input  logic [31:0]       ram_word,
  input  logic              run,
  input  logic              done,
  input  logic [ADDR_W-1:0] stop_cnt,
  output logic [TRIG_W-1:0] trig_val,
  output logic [TRIG_W-1:0] trig_care,
  output logic [ADDR_W-1:0] post_cnt,
  output logic              arm
);
  import la_cap_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic       req, wr, is_ctl;
  logic [1:0] sel;
  logic [31:0] rd_mux;

  assign req    = bus_cyc && bus_stb && !bus_ack;
  assign wr     = req && bus_we;
  assign is_ctl = bus_adr[BUS_AW-1];
  assign sel    = bus_adr[1:0];
  assign arm    = wr && is_ctl && sel == 2'd0 && bus_wdat[ST_ARM_BIT];

  always_comb begin
    rd_mux = ram_word;
    if (is_ctl) begin
      case (sel)
        2'd0:    begin
          rd_mux = 32'd0;
          rd_mux[ST_RUN_BIT]  = run;
          rd_mux[ST_DONE_BIT] = done;
        end
        2'd1:    rd_mux = 32'(stop_cnt);
        2'd2:    rd_mux = 32'(trig_val);
        default: rd_mux = 32'(trig_care);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdat  <= '0;
      trig_val  <= '0;
      trig_care <= '0;
      post_cnt  <= ADDR_W'(DEPTH / 2);
    end else begin
      bus_ack <= req;
      if (req) bus_rdat <= rd_mux;
      if (wr && is_ctl) begin
        case (sel)
          2'd1:    post_cnt  <= bus_wdat[ADDR_W-1:0];
          2'd2:    trig_val  <= bus_wdat[TRIG_W-1:0];
          2'd3:    trig_care <= bus_wdat[TRIG_W-1:0];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/la_capture_top.sv
module la_capture_top #(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 9,
  parameter int TRIG_W   = 8,
  localparam int LANES   = 32 / SAMPLE_W,
  localparam int NWORDS  = (1 << ADDR_W) / LANES,
  localparam int WORD_AW = $clog2(NWORDS),
  localparam int BUS_AW  = WORD_AW + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [TRIG_W-1:0]   trig_in,
  input  logic                bus_cyc,
  input  logic                bus_stb,
  input  logic                bus_we,
  input  logic [BUS_AW-1:0]   bus_adr,
  input  logic [31:0]         bus_wdat,
  output logic [31:0]         bus_rdat,
  output logic                bus_ack
);
  import la_cap_pkg::*;

  initial begin
    if (!(SAMPLE_W == 8 || SAMPLE_W == 16 || SAMPLE_W == 32))
      $error("SAMPLE_W must be 8, 16 or 32");
    if (TRIG_W < 1 || TRIG_W > 32) $error("TRIG_W must be 1..32");
    if (NWORDS < 2) $error("ADDR_W too small for SAMPLE_W");
  end

  logic              run, done, wr_en, trig_fire, cap_stop, arm, trig_hit;
  logic [ADDR_W-1:0] wr_ptr, stop_cnt, post_cnt;
  logic [TRIG_W-1:0] trig_val, trig_care;
  logic [31:0]       ram_word;

  assign trig_hit = trig_match(32'(trig_in), 32'(trig_val), 32'(trig_care));

  la_sample_ram #(
    .SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .WORD_AW(WORD_AW)
  ) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_ptr), .wr_data(smp_data),
    .rd_word(bus_adr[WORD_AW-1:0]), .rd_packed(ram_word)
  );

  la_capture_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst(rst), .arm(arm), .hit(trig_hit), .post_cnt(post_cnt),
    .run(run), .done(done), .wr_ptr(wr_ptr), .stop_cnt(stop_cnt),
    .wr_en(wr_en), .trig_fire(trig_fire), .cap_stop(cap_stop)
  );

  la_bus_regs #(.ADDR_W(ADDR_W), .TRIG_W(TRIG_W), .BUS_AW(BUS_AW)) u_regs (
    .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
    .bus_we(bus_we), .bus_adr(bus_adr), .bus_wdat(bus_wdat),
    .bus_rdat(bus_rdat), .bus_ack(bus_ack), .ram_word(ram_word),
    .run(run), .done(done), .stop_cnt(stop_cnt), .trig_val(trig_val),
    .trig_care(trig_care), .post_cnt(post_cnt), .arm(arm)
  );

endmodule

// File: rtl/la_capture_chk.sv
module la_capture_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              done,
  input logic              arm,
  input logic              cap_stop,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic [ADDR_W-1:0] stop_cnt,
  input logic              bus_cyc,
  input logic              bus_stb,
  input logic              bus_ack
);

  // R3
  run_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(run && done));

  // R1
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !arm) |=> wr_ptr == ADDR_W'($past(wr_ptr) + 1));

  // R5
  stop_latch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> stop_cnt == wr_ptr);

  // R5
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_stop |=> $stable(stop_cnt));

  // R4
  done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(run));

  // R6
  arm_effect_chk: assert property (@(posedge clk) disable iff (rst)
    arm |=> (run && !done && wr_ptr == '0));

  // R7
  ack_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_stb && !bus_ack) |=> bus_ack);

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

endmodule

bind la_capture_top la_capture_chk #(.ADDR_W(ADDR_W)) u_la_chk (
  .clk(clk), .rst(rst), .run(run), .done(done), .arm(arm),
  .cap_stop(cap_stop), .wr_ptr(wr_ptr), .stop_cnt(stop_cnt),
  .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_ack(bus_ack)
);

// File: tb/la_capture_top_bench.sv
module la_capture_top_bench;

  localparam int SW = 8, AW = 4, TW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int NW = DEPTH / 4;
  localparam int A_ST = NW, A_STOP = NW + 1, A_VAL = NW + 2, A_CARE = NW + 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] dcnt = 8'd0;
  logic bus_cyc = 0, bus_stb = 0, bus_we = 0;
  logic [2:0] bus_adr = '0;
  logic [31:0] bus_wdat = '0, bus_rdat;
  logic bus_ack;
  int checks = 0, errors = 0;
  logic [7:0] sbuf [DEPTH];

  always #10 clk = ~clk;
  always @(negedge clk) dcnt <= dcnt + 8'd1;

  la_capture_top #(.SAMPLE_W(SW), .ADDR_W(AW), .TRIG_W(TW)) u_la_capture_top (
    .clk(clk), .rst(rst), .smp_data(dcnt), .trig_in(dcnt),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
    .bus_wdat(bus_wdat), .bus_rdat(bus_rdat), .bus_ack(bus_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input int a, input bit we, input logic [31:0] wd,
                        output logic [31:0] rd);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = we; bus_adr = 3'(a); bus_wdat = wd;
    @(negedge clk);
    chk(bus_ack === 1'b1, "R7 ack after one cycle", 32'(bus_ack), 32'd1);
    rd = bus_rdat;
    bus_cyc = 0; bus_stb = 0; bus_we = 0;
    @(negedge clk);
    chk(bus_ack === 1'b0, "R7 ack single cycle", 32'(bus_ack), 32'd0);
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    access(a, 1'b0, 32'd0, d);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    logic [31:0] dummy;
    access(a, 1'b1, d, dummy);
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(A_ST, s);
      if (s[6]) break;
    end
    chk(s == 32'h40, "R3 finished status", s, 32'h40);
  endtask

  // R2: unpack lane j of word w into entry 4w+j
  task automatic dump();
    logic [31:0] d;
    for (int w = 0; w < NW; w++) begin
      rd(w, d);
      for (int j = 0; j < 4; j++) sbuf[4*w+j] = d[8*j +: 8];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    logic [7:0] tv, first;
    int stop, t;
    repeat (3) @(negedge clk);
    rst = 0;

    // R8 reset state
    rd(A_ST, d);   chk(d == 0, "R8 status after reset", d, 0);
    rd(A_STOP, d); chk(d == 0, "R8 stop after reset", d, 0);
    rd(A_VAL, d);  chk(d == 0, "R8 value after reset", d, 0);
    rd(A_CARE, d); chk(d == 0, "R8 mask after reset", d, 0);

    // R8 default post count depth/2 with all-zero mask
    wr(A_ST, 32'h80);
    wait_done();
    rd(A_STOP, d);
    chk(d == (DEPTH/2 + 1) % DEPTH, "R8 default post count", d, (DEPTH/2 + 1) % DEPTH);

    // R5 sweep of every post count, mask zero: trigger at entry 0
    for (int p = 0; p < DEPTH; p++) begin
      wr(A_STOP, 32'(p));
      wr(A_ST, 32'h80);
      wait_done();
      rd(A_STOP, d);
      chk(d == 32'((p + 1) % DEPTH), "R5 stop address", d, 32'((p + 1) % DEPTH));
      dump();
      for (int k = 1; k <= p; k++)
        chk(sbuf[k] == sbuf[0] + 8'(k), "R1 consecutive samples", 32'(sbuf[k]),
            32'(sbuf[0] + 8'(k)));
      if (p == 3) begin
        rd(0, d2);
        first = d2[7:0];
        chk(d2 == {first + 8'd3, first + 8'd2, first + 8'd1, first},
            "R2 lane packing", d2, {first + 8'd3, first + 8'd2, first + 8'd1, first});
        chk(d == 32'd4, "R9 stop word reads stop address", d, 32'd4);
      end
    end

    // R10 / R4 full compare, wrap several times
    tv = dcnt + 8'd80;
    wr(A_VAL, 32'(tv));
    wr(A_CARE, 32'hFF);
    wr(A_STOP, 32'd5);
    wr(A_ST, 32'h80);
    rd(A_ST, d);
    chk(d == 32'h80, "R6 armed status", d, 32'h80);
    wait_done();
    rd(A_STOP, d);
    stop = int'(d);
    dump();
    chk(sbuf[(stop + DEPTH - 6) % DEPTH] == tv, "R4 trigger sample",
        32'(sbuf[(stop + DEPTH - 6) % DEPTH]), 32'(tv));
    for (int k = 0; k < DEPTH; k++)
      chk(sbuf[(stop + k) % DEPTH] == tv + 8'd5 - 8'(DEPTH - 1) + 8'(k),
          "R10 oldest-first order", 32'(sbuf[(stop + k) % DEPTH]),
          32'(tv + 8'd5 - 8'(DEPTH - 1) + 8'(k)));

    // R4 partial mask: only low nibble compared
    wr(A_VAL, 32'hA5);
    wr(A_CARE, 32'h0F);
    wr(A_STOP, 32'd2);
    wr(A_ST, 32'h80);
    wait_done();
    rd(A_STOP, d);
    t = (int'(d) + DEPTH - 3) % DEPTH;
    dump();
    chk(sbuf[t][3:0] == 4'h5, "R4 masked match", 32'(sbuf[t]), 32'h5);
    chk(sbuf[(t+1)%DEPTH] == sbuf[t] + 8'd1 && sbuf[(t+2)%DEPTH] == sbuf[t] + 8'd2,
        "R5 post samples", 32'(sbuf[(t+2)%DEPTH]), 32'(sbuf[t] + 8'd2));
    for (int k = 0; k < t; k++)
      chk(sbuf[k][3:0] != 4'h5, "R4 first match only", 32'(sbuf[k]), 32'h5);

    // R7 sample-region write ignored; R6 status write without bit 7
    rd(1, d);
    wr(1, 32'hFFFF_FFFF);
    rd(1, d2);
    chk(d2 == d, "R7 sample write ignored", d2, d);
    wr(A_ST, 32'h7F);
    rd(A_ST, d);
    chk(d == 32'h40, "R6 no arm without bit 7", d, 32'h40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule